// File: doc/BRIEF.md
# SCSI Bus Phase Control Register

This block holds the byte that a small SCSI controller's processor writes to steer the information-transfer phase. When the controller acts as a target, the three phase bits and the request bit go straight onto the bus phase lines and the REQ line. A separate target-enable input gates them, and it comes from elsewhere in the controller. With target role off, every driven line stays low.

When the controller acts as an initiator with DMA switched on, the same three bits hold the phase the processor expects. The block synchronises the incoming REQ line and watches for its rising edge. If the live phase lines differ from the programmed bits at that edge, it raises a sticky interrupt, which the processor clears with a strobe. A transfer-permit output shows whether the live phase and the programmed phase agree, because an initiator may only move data while they match.

The block also keeps a last-byte flag for initiator DMA transfers. The flag is set only when the ACK handshake for the byte marked as final completes on the bus. The DMA engine handing that byte over does not set it. The start of a new DMA transfer clears the flag. All bus signals here are active-high; pad inversion and open-drain drivers sit outside the block.

Top module: `scsi_phase_ctl`

## Requirements
- R1: After reset, the register reads 0x00, all four driven bus lines are low, the interrupt is low, the last-byte flag is low and the transfer-permit output is 1 only if the live phase lines equal 000.
- R2: A write loads wr_data[3:0] into the register bits 3:0. Bits 6:4 always read 0. Bit 7 reads the last-byte flag, and a write to bit 7 has no effect on it.
- R3: With tgt_mode high, bus_io_out follows bit 0, bus_cd_out follows bit 1, bus_msg_out follows bit 2 and bus_req_out follows bit 3, from the cycle after the write.
- R4: With tgt_mode low, all four driven bus lines are low whatever the register holds, so the request bit has no effect in initiator role.
- R5: With tgt_mode low and dma_mode high, a rising edge on bus_req_in sets mismatch_irq if {bus_msg_in, bus_cd_in, bus_io_in} differs from bits 2:0. bus_req_in passes through SYNC_STAGES flops and one edge flop, so the flag rises at the third clock edge after the input rises (default SYNC_STAGES=2).
- R6: No interrupt is set when the phases match, when dma_mode is low, when tgt_mode is high, or while bus_req_in stays high with no new rising edge.
- R7: mismatch_irq holds until an irq_clr strobe. If a new mismatch and irq_clr fall in the same cycle, the interrupt stays set.
- R8: xfer_ok is 1 exactly when tgt_mode is low and the live phase lines equal bits 2:0.
- R9: The last-byte flag is set at the rising edge of bus_ack_in for the byte marked by dma_last, whether dma_last came earlier or in the same cycle. dma_start clears it and any pending mark, and dma_start wins over an ACK in the same cycle.
- R10: dma_last on its own, without an ACK, does not set the last-byte flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| irq_clr | input | 1 | Clears the mismatch interrupt |
| tgt_mode | input | 1 | Target role enable from the mode register |
| dma_mode | input | 1 | DMA mode enable |
| bus_io_in | input | 1 | Live I/O phase line |
| bus_cd_in | input | 1 | Live C/D phase line |
| bus_msg_in | input | 1 | Live MSG phase line |
| bus_req_in | input | 1 | Live REQ line (asynchronous) |
| bus_ack_in | input | 1 | ACK handshake from the initiator transfer logic |
| dma_start | input | 1 | New DMA transfer begins |
| dma_last | input | 1 | Current DMA byte is the final one |
| bus_io_out | output | 1 | Driven I/O line |
| bus_cd_out | output | 1 | Driven C/D line |
| bus_msg_out | output | 1 | Driven MSG line |
| bus_req_out | output | 1 | Driven REQ line |
| mismatch_irq | output | 1 | Sticky phase-mismatch interrupt |
| xfer_ok | output | 1 | Live phase matches programmed phase in initiator role |
| last_sent | output | 1 | Last byte of the DMA transfer has gone out |

## Verification
Two pairs of events can land on the same clock edge. In the first, a REQ rising edge is detected while the processor strobes irq_clr. The bench places the strobe on the exact third edge after REQ rises, and it passes only if the interrupt is still set afterwards. In the second, the ACK for a flagged last byte arrives together with dma_start. The bench drives both in one cycle and expects the last-byte flag and its bit in the read value to stay 0.

// File: rtl/scsi_phase_ctl.sv
module scsi_phase_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       irq_clr,
  input  logic       tgt_mode,
  input  logic       dma_mode,
  input  logic       bus_io_in,
  input  logic       bus_cd_in,
  input  logic       bus_msg_in,
  input  logic       bus_req_in,
  input  logic       bus_ack_in,
  input  logic       dma_start,
  input  logic       dma_last,
  output logic       bus_io_out,
  output logic       bus_cd_out,
  output logic       bus_msg_out,
  output logic       bus_req_out,
  output logic       mismatch_irq,
  output logic       xfer_ok,
  output logic       last_sent
);

  logic [2:0]             phase_q;
  logic                   req_bit_q;
  logic [SYNC_STAGES-1:0] req_sync;
  logic                   req_prev;
  logic                   ack_prev;
  logic                   last_pend;

  wire [2:0] live_phase = {bus_msg_in, bus_cd_in, bus_io_in};
  wire       initiator  = ~tgt_mode;
  wire       req_rise   = req_sync[SYNC_STAGES-1] & ~req_prev;
  wire       ack_rise   = bus_ack_in & ~ack_prev;
  wire       mis_set    = req_rise & initiator & dma_mode & (live_phase != phase_q);
  wire       last_hit   = ack_rise & initiator & dma_mode & (last_pend | dma_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= '0;
      req_bit_q <= 1'b0;
    end else if (wr_en) begin
      phase_q   <= wr_data[2:0];
      req_bit_q <= wr_data[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_sync <= '0;
      req_prev <= 1'b0;
      ack_prev <= 1'b0;
    end else begin
      req_sync <= {req_sync[SYNC_STAGES-2:0], bus_req_in};
      req_prev <= req_sync[SYNC_STAGES-1];
      ack_prev <= bus_ack_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mismatch_irq <= 1'b0;
    else if (mis_set) mismatch_irq <= 1'b1;
    else if (irq_clr) mismatch_irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || dma_start) begin
      last_sent <= 1'b0;
      last_pend <= 1'b0;
    end else if (last_hit) begin
      last_sent <= 1'b1;
      last_pend <= 1'b0;
    end else if (dma_last && initiator && dma_mode) begin
      last_pend <= 1'b1;
    end
  end

  assign bus_io_out  = tgt_mode & phase_q[0];
  assign bus_cd_out  = tgt_mode & phase_q[1];
  assign bus_msg_out = tgt_mode & phase_q[2];
  assign bus_req_out = tgt_mode & req_bit_q;
  assign xfer_ok     = initiator & (live_phase == phase_q);
  assign rd_data     = {last_sent, 3'b000, req_bit_q, phase_q};

endmodule

// File: rtl/scsi_phase_ctl_chk.sv
module scsi_phase_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq_clr,
  input logic       tgt_mode,
  input logic       dma_mode,
  input logic       bus_io_in,
  input logic       bus_cd_in,
  input logic       bus_msg_in,
  input logic       bus_req_in,
  input logic       bus_ack_in,
  input logic       dma_start,
  input logic       dma_last,
  input logic       bus_io_out,
  input logic       bus_cd_out,
  input logic       bus_msg_out,
  input logic       bus_req_out,
  input logic       mismatch_irq,
  input logic       xfer_ok,
  input logic       last_sent
);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:4] == 3'b000);

  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[3:0] == $past(wr_data[3:0]));

  a_r3_target_drive: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_mode |-> {bus_req_out, bus_msg_out, bus_cd_out, bus_io_out} == rd_data[3:0]);

  a_r4_initiator_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_mode |-> !(bus_req_out || bus_msg_out || bus_cd_out || bus_io_out));

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch_irq) |-> $past(dma_mode) && !$past(tgt_mode));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_irq && !irq_clr |=> mismatch_irq);

  a_r8_no_xfer_target: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_mode |-> !xfer_ok);

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !last_sent);

  a_r10_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_sent) |-> $past(bus_ack_in));

endmodule

bind scsi_phase_ctl scsi_phase_ctl_chk i_chk (.*);

// File: tb/test_scsi_phase_ctl.sv
module test_scsi_phase_ctl;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, irq_clr = 0, tgt_mode = 0, dma_mode = 0;
  logic [7:0] wr_data = 0;
  logic bus_io_in = 0, bus_cd_in = 0, bus_msg_in = 0, bus_req_in = 0, bus_ack_in = 0;
  logic dma_start = 0, dma_last = 0;
  logic [7:0] rd_data;
  logic bus_io_out, bus_cd_out, bus_msg_out, bus_req_out, mismatch_irq, xfer_ok, last_sent;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  scsi_phase_ctl i_scsi_phase_ctl (.*);

  // {tgt, wr[3:0], live[2:0], exp outs {req,msg,cd,io}, exp xfer_ok}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 4'hF, 3'b000, 4'hF, 1'b0},
    {1'b1, 4'h5, 3'b101, 4'h5, 1'b0},
    {1'b1, 4'hA, 3'b000, 4'hA, 1'b0},
    {1'b1, 4'h3, 3'b011, 4'h3, 1'b0},
    {1'b0, 4'hF, 3'b111, 4'h0, 1'b1},
    {1'b0, 4'h8, 3'b000, 4'h0, 1'b1},
    {1'b0, 4'h6, 3'b010, 4'h0, 1'b0},
    {1'b0, 4'h1, 3'b001, 4'h0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic live(input logic [2:0] p);
    {bus_msg_in, bus_cd_in, bus_io_in} = p;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 bus outs", {bus_req_out, bus_msg_out, bus_cd_out, bus_io_out}, 0);
    check("R1 irq/last", {mismatch_irq, last_sent}, 0);
    check("R1 xfer_ok", xfer_ok, 1);

    wr(8'hFF);
    check("R2 readback reserved and bit7", rd_data, 8'h0F);

    for (int k = 0; k < 8; k++) begin
      tgt_mode = VEC[k][12];
      live(VEC[k][7:5]);
      wr({4'h0, VEC[k][11:8]});
      check(VEC[k][12] ? "R3 target drive" : "R4 initiator quiet",
            {bus_req_out, bus_msg_out, bus_cd_out, bus_io_out}, VEC[k][4:1]);
      check("R8 xfer_ok", xfer_ok, VEC[k][0]);
    end

    tgt_mode = 0; dma_mode = 1;
    wr(8'h02); live(3'b001);
    bus_req_in = 1;
    step(2);
    check("R5 irq not before third edge", mismatch_irq, 0);
    step();
    check("R5 mismatch irq", mismatch_irq, 1);
    irq_clr = 1; step(); irq_clr = 0;
    check("R7 clear", mismatch_irq, 0);
    step(4);
    check("R6 held REQ no new edge", mismatch_irq, 0);
    bus_req_in = 0; step(4);

    live(3'b010); bus_req_in = 1; step(4);
    check("R6 matching phase", mismatch_irq, 0);
    bus_req_in = 0; step(4);

    live(3'b111); dma_mode = 0; bus_req_in = 1; step(4);
    check("R6 dma off", mismatch_irq, 0);
    bus_req_in = 0; step(4);

    dma_mode = 1; tgt_mode = 1; bus_req_in = 1; step(4);
    check("R6 target role", mismatch_irq, 0);
    bus_req_in = 0; step(4);

    tgt_mode = 0; bus_req_in = 1; step(2);
    irq_clr = 1; step(); irq_clr = 0;
    check("R7 set wins over clear", mismatch_irq, 1);
    step(2);
    check("R7 sticky", mismatch_irq, 1);
    irq_clr = 1; step(); irq_clr = 0;
    check("R7 clear after", mismatch_irq, 0);
    bus_req_in = 0; step(4);

    dma_start = 1; step(); dma_start = 0;
    dma_last = 1; step(); dma_last = 0;
    step(2);
    check("R10 no ack no flag", last_sent, 0);
    bus_ack_in = 1; step();
    check("R9 set on ack", last_sent, 1);
    check("R9 rd bit7", rd_data[7], 1);
    bus_ack_in = 0; step();
    wr(8'h00);
    check("R2 bit7 write ignored", rd_data, 8'h80);
    dma_start = 1; step(); dma_start = 0;
    check("R9 start clears", last_sent, 0);

    dma_last = 1; bus_ack_in = 1; step(); dma_last = 0; bus_ack_in = 0;
    check("R9 same-cycle mark and ack", last_sent, 1);
    step();
    dma_start = 1; step(); dma_start = 0;
    dma_last = 1; step(); dma_last = 0;
    dma_start = 1; bus_ack_in = 1; step(); dma_start = 0; bus_ack_in = 0;
    check("R9 start wins over ack", last_sent, 0);
    check("R9 rd bit7 after collision", rd_data[7], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule